// File: doc/BRIEF.md
# Round-Robin Thermal ADC Monitor

This block drives a shared 8-bit converter in a fixed rotation over three inputs: the thermistor voltage, the load-current monitor and one spare input. The converter spans 0 to 2 V, so one code step is 7.8125 mV. Each finished conversion is stored in a per-channel sample register, and any stored sample can be read through a select port. On channel 1 a code of 255 stands for full-scale load current.

Each new thermistor sample goes through two comparators with hysteresis. Each comparator drives an active-low flag: an early thermal warning and a hot indication. The thermistor voltage falls as temperature rises, so both flags trip when the code drops to a threshold. The hot flag trips at a lower voltage than the warning flag. The millivolt thresholds are turned into codes when the design is elaborated.

Top module: `thermal_adc_monitor`

## Requirements
- R1: `adc_start` is high for exactly one cycle per conversion. After reset it is high in the first cycle. After that it is high in the cycle that follows the cycle in which `adc_done` was accepted, and at no other time.
- R2: The channels are visited in the order 0 (thermistor), 1 (current), 2 (spare), and then the order wraps back to 0. `adc_chan` holds its value from the start pulse until `adc_done` is accepted.
- R3: When `adc_done` is accepted, `adc_data` is stored in the sample of the channel being converted, and the other samples keep their values. `rd_data` shows the sample chosen by `rd_sel` (0, 1 or 2). An `rd_sel` of 3 reads as 0.
- R4: An `adc_done` that arrives in the start-pulse cycle is ignored. It stores no sample and does not advance the channel.
- R5: The warning flag `alert_n` goes low when a new thermistor code is at or below 65, which is 508 mV rounded to the nearest code.
- R6: Once low, `alert_n` returns high only when a new thermistor code is above 67. The 490 mV level gives a band of 2 codes, added to 65. Codes from 66 to 67 leave `alert_n` unchanged.
- R7: The hot flag `hot_n` goes low when a new thermistor code is at or below 62 (488 mV). It returns high when a new code is above 64, using the 2-code band from 470 mV. Whenever `hot_n` is low, `alert_n` is also low.
- R8: The flags change only when a thermistor sample is accepted. Samples on channels 1 and 2 never change them, whatever the code.
- R9: Reset, which is asynchronous and active low, clears all samples to 0, sets both flags high (inactive) and sets the channel to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_start | output | 1 | One-cycle request to begin a conversion |
| adc_chan | output | 2 | Channel to convert (0 thermistor, 1 current, 2 spare) |
| adc_done | input | 1 | One-cycle conversion-complete strobe |
| adc_data | input | 8 | Conversion result, valid with `adc_done` |
| rd_sel | input | 2 | Sample register select |
| rd_data | output | 8 | Selected sample, or 0 when the select is 3 |
| alert_n | output | 1 | Early thermal warning, active low |
| hot_n | output | 1 | Hot indication, active low |

## Verification
The assertions assume the converter answers each start with exactly one `adc_done` pulse, one cycle long, and that `adc_data` is valid in that cycle. The bench converter model follows this and varies the latency from 1 to 5 cycles. Its one deliberate exception is an extra strobe placed in the start-pulse cycle, which checks that such a strobe is ignored. The thermistor codes step around both hysteresis bands, so each trip, hold and release edge is reached from both sides. Low codes are fed on the current and spare channels to show that the flags do not respond to them.

// File: rtl/thermal_mon_pkg.sv
package thermal_mon_pkg;

  // Millivolts to the nearest converter code for a given full scale.
  function automatic int mv_to_code(input int mv, input int full_mv, input int bits);
    return (mv * (1 << bits) + full_mv / 2) / full_mv;
  endfunction

  // Release code: the trip code plus the spacing between the two levels.
  function automatic int release_code(input int trip_mv, input int band_mv,
                                      input int full_mv, input int bits);
    int t;
    t = mv_to_code(trip_mv, full_mv, bits);
    return t + (t - mv_to_code(band_mv, full_mv, bits));
  endfunction

  function automatic int wrap_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/tam_sequencer.sv
module tam_sequencer
  import thermal_mon_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan,
  output logic            busy,
  output logic            cap_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      conv_chan <= '0;
    end else if (!busy) begin
      busy <= 1'b1;
    end else if (conv_done) begin
      busy      <= 1'b0;
      conv_chan <= CH_W'(wrap_next(int'(conv_chan), NUM_CH));
    end
  end

  assign conv_start = !busy;
  assign cap_en     = busy && conv_done;

endmodule

// File: rtl/tam_sample_bank.sv
module tam_sample_bank #(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_sel,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] smp [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        smp[g] <= '0;
      else if (wr_en && wr_idx == CH_W'(g))
        smp[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_sel == CH_W'(i)) rd_data = smp[i];
  end

endmodule

// File: rtl/tam_hyst_flag.sv
module tam_hyst_flag #(
  parameter int DATA_W    = 8,
  parameter int TRIP_CODE = 65,
  parameter int FREE_CODE = 67
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp,
  output logic              flag_n
);

  localparam logic [DATA_W-1:0] TRIP_C = DATA_W'(TRIP_CODE);
  localparam logic [DATA_W-1:0] FREE_C = DATA_W'(FREE_CODE);

  logic trip, free;
  assign trip = smp <= TRIP_C;
  assign free = smp > FREE_C;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_n <= 1'b1;
    else if (smp_vld) begin
      if (trip)      flag_n <= 1'b0;
      else if (free) flag_n <= 1'b1;
    end
  end

endmodule

// File: rtl/thermal_adc_monitor.sv
module thermal_adc_monitor
  import thermal_mon_pkg::*;
#(
  parameter int NUM_CH        = 3,
  parameter int DATA_W        = 8,
  parameter int FULL_MV       = 2000,
  parameter int TEMP_CH       = 0,
  parameter int WARN_TRIP_MV  = 508,
  parameter int WARN_BAND_MV  = 490,
  parameter int HOT_TRIP_MV   = 488,
  parameter int HOT_BAND_MV   = 470
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              adc_start,
  output logic [1:0]        adc_chan,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              alert_n,
  output logic              hot_n
);

  localparam int CH_W      = 2;
  localparam int WARN_TRIP = mv_to_code(WARN_TRIP_MV, FULL_MV, DATA_W);
  localparam int WARN_FREE = release_code(WARN_TRIP_MV, WARN_BAND_MV, FULL_MV, DATA_W);
  localparam int HOT_TRIP  = mv_to_code(HOT_TRIP_MV, FULL_MV, DATA_W);
  localparam int HOT_FREE  = release_code(HOT_TRIP_MV, HOT_BAND_MV, FULL_MV, DATA_W);

  logic busy, cap_en, temp_vld;

  tam_sequencer #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .conv_done(adc_done),
    .conv_start(adc_start), .conv_chan(adc_chan),
    .busy(busy), .cap_en(cap_en)
  );

  tam_sample_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_en), .wr_idx(adc_chan),
    .wr_data(adc_data), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  assign temp_vld = cap_en && (adc_chan == CH_W'(TEMP_CH));

  tam_hyst_flag #(.DATA_W(DATA_W), .TRIP_CODE(WARN_TRIP), .FREE_CODE(WARN_FREE)) u_warn (
    .clk(clk), .rst_n(rst_n), .smp_vld(temp_vld), .smp(adc_data), .flag_n(alert_n)
  );

  tam_hyst_flag #(.DATA_W(DATA_W), .TRIP_CODE(HOT_TRIP), .FREE_CODE(HOT_FREE)) u_hot (
    .clk(clk), .rst_n(rst_n), .smp_vld(temp_vld), .smp(adc_data), .flag_n(hot_n)
  );

endmodule

// File: rtl/thermal_adc_monitor_chk.sv
module thermal_adc_monitor_chk #(
  parameter int LAST_CH = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       adc_start,
  input logic       adc_done,
  input logic [1:0] adc_chan,
  input logic       busy,
  input logic       cap_en,
  input logic       temp_vld,
  input logic       alert_n,
  input logic       hot_n
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R1
  AST_START_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> adc_start); // R1
  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_chan <= 2'(LAST_CH)); // R2
  AST_CHAN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && adc_chan == 2'(LAST_CH)) |=> adc_chan == 2'd0); // R2
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(adc_chan)); // R2
  AST_EARLY_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && adc_done) |=> (busy && $stable(adc_chan))); // R4
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_vld |=> ($stable(alert_n) && $stable(hot_n))); // R8
  AST_HOT_NEEDS_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    !hot_n |-> !alert_n); // R7

endmodule

bind thermal_adc_monitor thermal_adc_monitor_chk #(.LAST_CH(NUM_CH - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_done(adc_done),
  .adc_chan(adc_chan), .busy(busy), .cap_en(cap_en), .temp_vld(temp_vld),
  .alert_n(alert_n), .hot_n(hot_n)
);

// File: tb/thermal_adc_monitor_test.sv
`timescale 1ns/1ps
module thermal_adc_monitor_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adc_done = 1'b0;
  logic [7:0] adc_data = 8'd0;
  logic [1:0] rd_sel = 2'd0;
  logic       adc_start, alert_n, hot_n;
  logic [1:0] adc_chan;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  thermal_adc_monitor uut (
    .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_chan(adc_chan),
    .adc_done(adc_done), .adc_data(adc_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .alert_n(alert_n), .hot_n(hot_n)
  );

  // Threshold codes restated from the requirements with real arithmetic.
  function automatic int thr(real mv);
    return $rtoi(mv * 256.0 / 2000.0 + 0.5);
  endfunction
  int w_on, w_off, h_on, h_off;

  // Behavioural reference model.
  bit m_wait = 0;
  int m_chan = 0;
  int m_smp[3] = '{0, 0, 0};
  bit m_alert_n = 1, m_hot_n = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wait = 0; m_chan = 0; m_smp = '{0, 0, 0}; m_alert_n = 1; m_hot_n = 1;
    end else if (!m_wait) begin
      m_wait = 1;
    end else if (adc_done) begin
      m_smp[m_chan] = adc_data;
      if (m_chan == 0) begin
        if (adc_data <= w_on) m_alert_n = 0; else if (adc_data > w_off) m_alert_n = 1;
        if (adc_data <= h_on) m_hot_n = 0;   else if (adc_data > h_off) m_hot_n = 1;
      end
      m_chan = (m_chan + 1) % 3;
      m_wait = 0;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(adc_start == !m_wait, "R1", "adc_start", adc_start, !m_wait);
      chk(adc_chan == m_chan, "R2", "adc_chan", adc_chan, m_chan);
      chk(rd_data == ((rd_sel < 3) ? m_smp[rd_sel] : 0), "R3 R4", "rd_data", rd_data,
          (rd_sel < 3) ? m_smp[rd_sel] : 0);
      chk(alert_n == m_alert_n, "R5 R6 R8", "alert_n", alert_n, m_alert_n);
      chk(hot_n == m_hot_n, "R7 R8", "hot_n", hot_n, m_hot_n);
    end
  end

  always @(negedge clk) #2 rd_sel <= rd_sel + 2'd1;

  // One conversion; optional extra strobe in the start cycle (R4).
  task automatic conv(int lat, int d, bit early);
    while (!adc_start) @(negedge clk);
    if (early) begin #1 adc_done = 1; adc_data = 8'd3; end
    repeat (lat) begin @(negedge clk); #1 adc_done = 0; end
    adc_done = 1; adc_data = 8'(d);
    @(negedge clk); #1 adc_done = 0;
  endtask

  task automatic pass3(int t, int c, int s, int lat);
    conv(lat, t, 0);
    conv(lat % 5 + 1, c, lat == 2);
    conv(lat, s, 0);
  endtask

  task automatic pulse_reset();
    @(negedge clk); #1 rst_n = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
    #0.5;
    chk(alert_n == 1 && hot_n == 1, "R9", "flags after reset", {alert_n, hot_n}, 3);
    chk(adc_start == 1, "R9", "start after reset", adc_start, 1);
    chk(adc_chan == 0, "R9", "chan after reset", adc_chan, 0);
    chk(rd_data == 0, "R9", "sample after reset", rd_data, 0);
  endtask

  task automatic finish_up();
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200_000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    int temps[14] = '{100, 66, 65, 63, 67, 68, 62, 64, 65, 60, 90, 66, 61, 200};
    w_on = thr(508.0); w_off = w_on + (w_on - thr(490.0));
    h_on = thr(488.0); h_off = h_on + (h_on - thr(470.0));
    pulse_reset();
    foreach (temps[i]) pass3(temps[i], (i * 37) % 256, (i % 2) ? 0 : 255, i % 5 + 1);
    pass3(50, 10, 5, 1);                // both flags low, R5 R7
    pulse_reset();                      // R9 clears flags and samples
    pass3(120, 0, 1, 3);                // low codes on channels 1, 2: R8
    pass3(64, 0, 0, 2);                 // hot band edge, early strobe R4
    pass3(61, 255, 2, 4);
    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule